// File: doc/BRIEF.md
# FFT Input Fold-or-Pad Front End

This block sits in front of a power-of-two FFT and turns a real-valued record of any length into a record of exactly the transform length. The length of each record is presented together with its first sample. If the record is only a little longer than a power of two P, the block wraps it around onto P slots and adds the samples that land on the same slot. The limit is a length of at most √2·P. A record that is longer than that is instead extended with zeros up to the next power of two above it. This keeps the data passed downstream close to the record size and avoids nearly doubling it.

Samples arrive on a valid/ready stream and are accumulated into a single internal RAM. Output begins once the last sample of the record has been taken. The output is a valid/last stream of exactly N words, and the chosen size N is shown alongside it. The output stream has no back-pressure: the consumer must accept one word on every cycle while the output is valid. No new record is accepted until the current output has been sent in full.

Top module: `fft_fold_pad`

## Requirements
- R1: For a record length L (1 ≤ L ≤ ⌊√2·MAXN⌋), the chosen size N is as follows. If L < MINN, N is MINN. Otherwise let P be the largest power of two not above L. If L equals P, N is P. If L·L ≤ 2·P·P, N is P. In every other case, N is 2·P. N is always a power of two within [MINN, MAXN].
- R2: When L > N, output word k is the exact sum of every input sample i with i mod N = k.
- R3: When L ≤ N, output word k is input sample k for k < L, and zero for L ≤ k < N.
- R4: The output is never valid while input is being accepted. `in_ready` is low for the whole time `out_valid` is high.
- R5: Each record produces exactly N output words, and `out_last` is high on the final word only.
- R6: `out_size` carries N and stays constant for all the output words of a record.
- R7: Samples are two's-complement and are summed at full precision in DW+1 bits with no saturation. Word k is therefore exact even when every sample is at either extreme.
- R8: After reset, `in_ready` is 1 and `out_valid` is 0.
- R9: `in_len` is sampled only with the first accepted sample of a record. Changes to it during the rest of the record have no effect. A new record can start on the cycle after `out_last`.
- R10: Cycles in which `in_valid` is low do not advance the record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_len | input | LW | Record length, taken with the first sample |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block is accepting input |
| in_data | input | DW | Signed real input sample |
| out_valid | output | 1 | Output word valid |
| out_last | output | 1 | Final word of the transform record |
| out_data | output | DW+1 | Signed folded or padded word |
| out_size | output | LW | Chosen transform size N |

## Verification
Faults in the internal state appear at the ports in different ways. A wrong slot address or a missed first write corrupts specific output words, so a full record comparison points to the fault within the same record. A wrong sample count or size register makes the output phase start early or late, or end on a word other than N−1. That shows up at the first output word or at `out_last`. A length register that follows `in_len` after the first sample changes the zero tail or the fold point, so the bench alters `in_len` mid-record to expose it.

// File: rtl/fft_fold_pad.sv
module fft_fold_pad #(
  parameter int DW   = 16,
  parameter int MAXN = 256,
  parameter int MINN = 64,
  localparam int AB  = $clog2(MAXN),
  localparam int LW  = AB + 1,
  localparam int AW  = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LW-1:0]        in_len,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_last,
  output logic signed [AW-1:0] out_data,
  output logic [LW-1:0]        out_size
);

  function automatic logic [LW-1:0] pick_size(input logic [LW-1:0] l);
    logic [2*LW:0] p, ll, pp2;
    p = '0;
    for (int k = 0; k < LW; k++)
      if (l[k]) begin
        p = '0;
        p[k] = 1'b1;
      end
    ll  = (2*LW+1)'(l) * (2*LW+1)'(l);
    pp2 = (p * p) << 1;
    if (int'(l) < MINN)            return LW'(MINN);
    else if ((2*LW+1)'(l) == p)    return LW'(p);
    else if (ll <= pp2)            return LW'(p);
    else                           return LW'(p << 1);
  endfunction

  logic                 phase;
  logic [LW-1:0]        cnt, len_q, n_q;
  logic signed [AW-1:0] mem [MAXN];

  wire               first  = (cnt == '0);
  wire  [LW-1:0]     n_cur  = first ? pick_size(in_len) : n_q;
  wire  [LW-1:0]     l_cur  = first ? in_len : len_q;
  wire  [LW-1:0]     n_msk  = n_cur - 1'b1;
  wire  [AB-1:0]     waddr  = cnt[AB-1:0] & n_msk[AB-1:0];
  wire               fire   = in_valid && in_ready;
  wire signed [AW-1:0] sx   = {in_data[DW-1], in_data};
  wire signed [AW-1:0] wval = (cnt < n_cur) ? sx : mem[waddr] + sx;

  assign in_ready  = !phase;
  assign out_valid = phase;
  assign out_last  = phase && (cnt == n_q - 1'b1);
  assign out_size  = n_q;
  assign out_data  = (phase && cnt < len_q) ? mem[cnt[AB-1:0]] : '0;

  always_ff @(posedge clk)
    if (fire) mem[waddr] <= wval;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
      n_q   <= LW'(MINN);
    end else if (!phase) begin
      if (fire) begin
        if (first) begin
          len_q <= in_len;
          n_q   <= n_cur;
        end
        if (cnt == l_cur - 1'b1) begin
          phase <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      if (out_last) begin
        phase <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_size_legal_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($onehot(out_size) && int'(out_size) >= MINN && int'(out_size) <= MAXN));

  p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && in_ready));

  p_last_ends_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> !out_valid);

  p_size_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && $stable(out_size)));

  p_ready_after_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |=> in_ready);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (in_ready && !out_valid));

endmodule

// File: tb/fft_fold_pad_test.sv
module fft_fold_pad_test;
  localparam int DW = 16, MAXN = 256, MINN = 64, LW = 9, LMAX = 362;

  logic clk = 0, rst = 1;
  logic [LW-1:0] in_len = '0;
  logic in_valid = 0, in_ready, out_valid, out_last;
  logic signed [DW-1:0] in_data = '0;
  logic signed [DW:0] out_data;
  logic [LW-1:0] out_size;

  fft_fold_pad #(.DW(DW), .MAXN(MAXN), .MINN(MINN)) uut (
    .clk(clk), .rst(rst), .in_len(in_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_last(out_last),
    .out_data(out_data), .out_size(out_size));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit timeout = 0;
  int smp [0:LMAX];
  int expv [0:MAXN-1];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) timeout = 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_size(input int l);
    int up = MINN;
    while (up < l) up *= 2;
    if (up == l) return up;
    if (up / 2 >= MINN && l * l <= 2 * (up / 2) * (up / 2)) return up / 2;
    return up;
  endfunction

  task automatic run_record(input int l, input int mode, input int gap_pct);
    int n, i, beats, bad, bad_k, bad_a, bad_e, size0;
    bit busy_bad, last_bad, size_bad;
    n = exp_size(l);
    for (int k = 0; k < l; k++)
      smp[k] = (mode == 1) ? -32768 : (mode == 2) ? 32767 : int'($signed(16'($urandom)));
    for (int k = 0; k < n; k++) expv[k] = 0;
    for (int k = 0; k < l; k++) expv[k % n] += smp[k];
    i = 0; busy_bad = 0;
    while (i < l && !timeout) begin
      @(negedge clk);
      if (out_valid) busy_bad = 1;
      in_valid = (($urandom % 100) >= gap_pct);
      in_data  = 16'(smp[i]);
      in_len   = (i == 0) ? LW'(l) : LW'($urandom);
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 0;
    in_len = LW'($urandom);
    beats = 0; bad = 0; bad_k = 0; bad_a = 0; bad_e = 0; last_bad = 0; size_bad = 0;
    size0 = int'(out_size);
    chk(out_valid && size0 == n, "R1 size", size0, n);
    while (out_valid && !timeout) begin
      if (in_ready) busy_bad = 1;
      if (int'(out_size) != size0) size_bad = 1;
      if (beats < n) begin
        if (int'(out_data) != expv[beats]) begin
          if (bad == 0) begin bad_k = beats; bad_a = int'(out_data); bad_e = expv[beats]; end
          bad++;
        end
      end
      if (out_last != (beats == n - 1)) last_bad = 1;
      beats++;
      if (out_last) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    if (l > n) chk(bad == 0, mode != 0 ? "R7 extreme fold sum" : "R2 fold sum", bad_a, bad_e);
    else       chk(bad == 0, mode != 0 ? "R7 extreme pad" : "R3 pad/zero tail", bad_a, bad_e);
    if (bad != 0) $display("  (first mismatch at word %0d, L=%0d N=%0d)", bad_k, l, n);
    chk(beats == n && !last_bad, "R5 beat count/last", beats, n);
    chk(!busy_bad, "R4 no overlap of in/out", int'(busy_bad), 0);
    chk(!size_bad, "R6 size stable", int'(size_bad), 0);
    chk(in_ready && !out_valid, "R9 ready for next record", int'(in_ready), 1);
  endtask

  initial begin
    int dl [13] = '{1, 63, 64, 65, 90, 91, 128, 181, 182, 200, 256, 300, 362};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R8 reset state", int'(in_ready), 1);
    in_valid = 0;
    repeat (20) @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R10 idle no advance", int'(out_valid), 0);
    foreach (dl[j]) run_record(dl[j], 0, 0);
    run_record(362, 1, 30);
    run_record(362, 2, 0);
    run_record(100, 1, 0);
    for (int r = 0; r < 20 && !timeout; r++)
      run_record(1 + int'($urandom % LMAX), 0, 40);
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (timeout);
    repeat (5) @(negedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule